// File: doc/BRIEF.md
# Short I/O Slave Window Decoder

This block is the slave side of a small command and status window on a VME-style backplane. It watches the address modifier, the address lines, the address strobe, the two data strobes and the longword request. It answers only short I/O cycles, in either the nonprivileged or the supervisory flavour. In such a cycle only the low 16 address lines count. Bits [15:9] select a 512-byte window whose base comes from a static switch input. A hit reads or writes an on-board RAM of 256 16-bit words and returns a data acknowledge.

Every strobe and control input is modelled active-high: 1 means asserted. A cycle that does not match is ignored silently. It draws no acknowledge and no bus error. The data bus is modelled as a data word plus an output enable, which stands in for the tri-state driver. Only 8-bit and 16-bit transfers are served.

Top module: `sio_window_slave`

## Requirements
- R1: A cycle is acknowledged only when the 6-bit address modifier is 0x29 (nonprivileged short I/O) or 0x2D (supervisory short I/O). Every other modifier value draws no acknowledge and leaves the RAM unchanged.
- R2: Address bits [31:16] have no effect on decoding, on the selected word or on the data.
- R3: A hit needs address bits [15:9] to equal `base_sw_i`. Bits [8:1] then select one of 256 words, and bit 0 selects the byte. Any other value of bits [15:9] draws no acknowledge and writes nothing.
- R4: A cycle with `lword_i` asserted is never acknowledged and never writes.
- R5: A byte access asserts exactly one data strobe. Address bit 0 = 0 selects the even byte, carried on data bits [15:8]. Address bit 0 = 1 selects the odd byte, carried on bits [7:0]. A byte write changes only that byte.
- R6: A word access asserts both data strobes with address bit 0 = 0 and moves all 16 bits. Both strobes together with address bit 0 = 1 is a misaligned word and is not acknowledged.
- R7: `dtack_o` rises at the first clock edge that samples a valid decode while the slave is idle. It stays high as long as either data strobe is asserted. It falls at the first edge that samples both strobes released.
- R8: `dout_oe_o` is high only while `dtack_o` is high in a read cycle. A read returns the addressed data, and the lane that was not selected by a byte read reads as zero.
- R9: A non-matching cycle is ignored silently. There is no acknowledge, no output enable and no RAM change.
- R10: After reset, `dtack_o` and `dout_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| am_i | input | 6 | Address modifier |
| addr_i | input | 32 | Address lines, byte address |
| lword_i | input | 1 | Longword (32-bit) transfer request |
| as_i | input | 1 | Address strobe, asserted high |
| ds0_i | input | 1 | Data strobe 0, asserted high |
| ds1_i | input | 1 | Data strobe 1, asserted high |
| write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| wdata_i | input | 16 | Write data from the bus |
| base_sw_i | input | 7 | Window base switches, compared with address bits [15:9] |
| rdata_o | output | 16 | Read data toward the bus |
| dout_oe_o | output | 1 | Read data drive enable |
| dtack_o | output | 1 | Data acknowledge, asserted high |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit data path, a 512-byte window and the codes 0x29 and 0x2D, with the base switches fixed at 0x15. At this size the bench writes and reads back all 256 words with varied upper address bits. It also sweeps all 64 modifier values and all 127 foreign base values against a shadow copy of the RAM. Byte lanes, longword cycles and misaligned words are covered as well. The same size puts every corner of the acknowledge handshake within reach: its rise, its hold and its release.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int SIO_AM_W      = 6;
    localparam int SIO_DW        = 16;
    localparam int SIO_LANES     = SIO_DW / 8;
    localparam int SIO_DEC_W     = 16;
    localparam int SIO_WIN_BYTES = 512;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_ACK  = 1'b1
    } sio_phase_e;

    typedef struct packed {
        sio_phase_e          phase;
        logic                is_read;
        logic [SIO_DW-1:0]   rdata;
    } sio_state_t;
endpackage

// File: rtl/sio_decode.sv
module sio_decode #(
    parameter logic [5:0] AM_USER  = 6'h29,
    parameter logic [5:0] AM_SUPER = 6'h2D,
    parameter int DEC_W  = 16,
    parameter int OFS_W  = 9,
    parameter int BASE_W = DEC_W - OFS_W,
    parameter int IDX_W  = OFS_W - 1
) (
    input  logic [5:0]        am,
    input  logic [DEC_W-1:0]  addr,
    input  logic              as_s,
    input  logic              ds0,
    input  logic              ds1,
    input  logic              lword,
    input  logic [BASE_W-1:0] base,
    output logic              valid,
    output logic [1:0]        be,
    output logic [IDX_W-1:0]  idx
);
    logic am_ok;
    logic base_hit;
    logic single;
    logic both;
    logic lane_ok;

    always_comb begin
        am_ok    = (am == AM_USER) || (am == AM_SUPER);
        base_hit = (addr[DEC_W-1:OFS_W] == base);
        single   = ds0 ^ ds1;
        both     = ds0 & ds1;
        // a word must start on an even byte
        lane_ok  = single | (both & ~addr[0]);
        valid    = as_s & am_ok & base_hit & lane_ok & ~lword;
        if (both) begin
            be = 2'b11;
        end else if (addr[0]) begin
            be = 2'b01;             // odd byte, low lane
        end else begin
            be = 2'b10;             // even byte, high lane
        end
        idx = addr[OFS_W-1:1];
    end
endmodule

// File: rtl/sio_ram.sv
module sio_ram #(
    parameter int WORDS = 256,
    parameter int IDX_W = $clog2(WORDS),
    parameter int LANES = 2,
    parameter int DW    = LANES * 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [LANES-1:0] be,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] mem [WORDS];

        always_ff @(posedge clk) begin
            if (we && be[g]) begin
                mem[idx] <= wdata[g*8 +: 8];
            end
        end

        assign rdata[g*8 +: 8] = mem[idx];
    end
endmodule

// File: rtl/sio_window_slave.sv
module sio_window_slave
    import sio_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [SIO_AM_W-1:0] AM_USER  = 6'h29,
    parameter logic [SIO_AM_W-1:0] AM_SUPER = 6'h2D,
    parameter int OFS_W  = $clog2(SIO_WIN_BYTES),
    parameter int BASE_W = SIO_DEC_W - OFS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SIO_AM_W-1:0] am_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                lword_i,
    input  logic                as_i,
    input  logic                ds0_i,
    input  logic                ds1_i,
    input  logic                write_i,
    input  logic [SIO_DW-1:0]   wdata_i,
    input  logic [BASE_W-1:0]   base_sw_i,
    output logic [SIO_DW-1:0]   rdata_o,
    output logic                dout_oe_o,
    output logic                dtack_o
);
    localparam int WORDS = SIO_WIN_BYTES / SIO_LANES;
    localparam int IDX_W = OFS_W - 1;

    sio_state_t st_d, st_q;

    logic                 dec_valid;
    logic [SIO_LANES-1:0] dec_be;
    logic [IDX_W-1:0]     dec_idx;
    logic [SIO_DW-1:0]    ram_rdata;
    logic [SIO_DW-1:0]    lane_mask;
    logic                 ram_we;
    logic                 unused_upper;

    // upper address half plays no part in short I/O
    assign unused_upper = ^addr_i[ADDR_W-1:SIO_DEC_W];

    sio_decode #(
        .AM_USER (AM_USER),
        .AM_SUPER(AM_SUPER),
        .DEC_W   (SIO_DEC_W),
        .OFS_W   (OFS_W),
        .BASE_W  (BASE_W),
        .IDX_W   (IDX_W)
    ) u_decode (
        .am   (am_i),
        .addr (addr_i[SIO_DEC_W-1:0]),
        .as_s (as_i),
        .ds0  (ds0_i),
        .ds1  (ds1_i),
        .lword(lword_i),
        .base (base_sw_i),
        .valid(dec_valid),
        .be   (dec_be),
        .idx  (dec_idx)
    );

    sio_ram #(
        .WORDS(WORDS),
        .IDX_W(IDX_W),
        .LANES(SIO_LANES),
        .DW   (SIO_DW)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .be   (dec_be),
        .idx  (dec_idx),
        .wdata(wdata_i),
        .rdata(ram_rdata)
    );

    for (genvar g = 0; g < SIO_LANES; g++) begin : g_mask
        assign lane_mask[g*8 +: 8] = {8{dec_be[g]}};
    end

    always_comb begin
        st_d   = st_q;
        ram_we = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (dec_valid) begin
                    st_d.phase   = PH_ACK;
                    st_d.is_read = ~write_i;
                    st_d.rdata   = ram_rdata & lane_mask;
                    ram_we       = write_i;
                end
            end
            PH_ACK: begin
                if (!ds0_i && !ds1_i) begin
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, is_read: 1'b0, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dtack_o   = (st_q.phase == PH_ACK);
    assign dout_oe_o = (st_q.phase == PH_ACK) && st_q.is_read;
    assign rdata_o   = st_q.rdata;
endmodule

// File: rtl/sio_window_chk.sv
module sio_window_chk #(
    parameter int ADDR_W = 32,
    parameter logic [5:0] AM_USER  = 6'h29,
    parameter logic [5:0] AM_SUPER = 6'h2D,
    parameter int DEC_W  = 16,
    parameter int BASE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        am_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              lword_i,
    input logic              as_i,
    input logic              ds0_i,
    input logic              ds1_i,
    input logic [BASE_W-1:0] base_sw_i,
    input logic              dout_oe_o,
    input logic              dtack_o
);
    localparam int OFS_W = DEC_W - BASE_W;

    a_r1_am_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_o) |-> ($past(am_i) == AM_USER || $past(am_i) == AM_SUPER));

    a_r3_base_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_o) |-> ($past(addr_i[DEC_W-1:OFS_W]) == $past(base_sw_i)));

    a_r4_no_longword: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_o) |-> !$past(lword_i));

    a_r7_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_o) |-> $past(as_i));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dtack_o && (ds0_i || ds1_i)) |=> dtack_o);

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (dtack_o && !ds0_i && !ds1_i) |=> !dtack_o);

    a_r8_oe_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe_o |-> dtack_o);
endmodule

bind sio_window_slave sio_window_chk #(
    .ADDR_W  (ADDR_W),
    .AM_USER (AM_USER),
    .AM_SUPER(AM_SUPER),
    .DEC_W   (sio_pkg::SIO_DEC_W),
    .BASE_W  (BASE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .am_i     (am_i),
    .addr_i   (addr_i),
    .lword_i  (lword_i),
    .as_i     (as_i),
    .ds0_i    (ds0_i),
    .ds1_i    (ds1_i),
    .base_sw_i(base_sw_i),
    .dout_oe_o(dout_oe_o),
    .dtack_o  (dtack_o)
);

// File: tb/test_sio_window_slave.sv
module test_sio_window_slave;
    localparam logic [6:0] BASE = 7'h15;
    localparam logic [5:0] AM_U = 6'h29;
    localparam logic [5:0] AM_S = 6'h2D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  am = 6'h0;
    logic [31:0] addr = 32'h0;
    logic        lword = 1'b0;
    logic        as_s = 1'b0;
    logic        ds0 = 1'b0;
    logic        ds1 = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        oe;
    logic        dtack;

    int checks = 0;
    int failures = 0;
    logic [15:0] model [256];

    always #10 clk = ~clk;

    sio_window_slave i_sio_window_slave (
        .clk(clk), .rst_n(rst_n), .am_i(am), .addr_i(addr), .lword_i(lword),
        .as_i(as_s), .ds0_i(ds0), .ds1_i(ds1), .write_i(wr), .wdata_i(wdata),
        .base_sw_i(BASE), .rdata_o(rdata), .dout_oe_o(oe), .dtack_o(dtack)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] waddr(input logic [15:0] upper, input logic [6:0] b,
                                          input int w, input bit odd);
        return {upper, b, w[7:0], odd};
    endfunction

    // one bus cycle; exp_rd is the full expected read word
    task automatic cycle(input logic [5:0] a_m, input logic [31:0] a, input bit lw, input bit w,
                         input bit d0, input bit d1, input logic [15:0] wd,
                         input bit exp_ack, input logic [15:0] exp_rd, input string tag);
        @(negedge clk);
        am = a_m; addr = a; lword = lw; wr = w; wdata = wd;
        as_s = 1'b1; ds0 = d0; ds1 = d1;
        @(negedge clk);
        chk(dtack == exp_ack, {tag, " R7 dtack after decode"}, 32'(dtack), 32'(exp_ack));
        chk(oe == (exp_ack && !w), {tag, " R8 drive enable"}, 32'(oe), 32'(exp_ack && !w));
        if (exp_ack && !w)
            chk(rdata == exp_rd, {tag, " R8 read data"}, 32'(rdata), 32'(exp_rd));
        @(negedge clk);
        chk(dtack == exp_ack, {tag, " R7 dtack held"}, 32'(dtack), 32'(exp_ack));
        as_s = 1'b0; ds0 = 1'b0; ds1 = 1'b0;
        @(negedge clk);
        chk(dtack == 1'b0 && oe == 1'b0, {tag, " R7 dtack released"}, 32'({dtack, oe}), 32'h0);
    endtask

    task automatic verify_word(input int w, input string tag);
        cycle(AM_S, waddr(16'hBEEF, BASE, w, 1'b0), 1'b0, 1'b0, 1'b1, 1'b1, 16'h0,
              1'b1, model[w], tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dtack == 1'b0, "R10 dtack in reset", 32'(dtack), 0);
        chk(oe == 1'b0, "R10 oe in reset", 32'(oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dtack == 1'b0 && oe == 1'b0, "R10 idle after reset", 32'({dtack, oe}), 0);

        // R3 R6 R2: fill every word, upper address bits varied
        for (int i = 0; i < 256; i++) begin
            model[i] = 16'((i * 40503) ^ 16'h5A3C);
            cycle((i % 2) ? AM_U : AM_S, waddr(16'(i * 16'h0101), BASE, i, 1'b0), 1'b0, 1'b1,
                  1'b1, 1'b1, model[i], 1'b1, 16'h0, "R3 word write");
        end
        for (int i = 0; i < 256; i++) begin
            cycle((i % 2) ? AM_S : AM_U, waddr(16'(~i), BASE, i, 1'b0), 1'b0, 1'b0,
                  1'b1, 1'b1, 16'h0, 1'b1, model[i], "R2 R6 word read");
        end

        // R5 byte lanes
        for (int i = 0; i < 256; i += 17) begin
            logic [7:0] ev, od;
            ev = 8'(i ^ 8'hC3);
            od = 8'(i + 8'h11);
            cycle(AM_U, waddr(16'h0, BASE, i, 1'b0), 1'b0, 1'b1, 1'b1, 1'b0, {ev, 8'h77},
                  1'b1, 16'h0, "R5 even byte write");
            model[i][15:8] = ev;
            cycle(AM_S, waddr(16'hFFFF, BASE, i, 1'b1), 1'b0, 1'b1, 1'b0, 1'b1, {8'h99, od},
                  1'b1, 16'h0, "R5 odd byte write");
            model[i][7:0] = od;
            cycle(AM_U, waddr(16'h1234, BASE, i, 1'b0), 1'b0, 1'b0, 1'b0, 1'b1, 16'h0,
                  1'b1, {model[i][15:8], 8'h00}, "R5 R8 even byte read");
            cycle(AM_U, waddr(16'h4321, BASE, i, 1'b1), 1'b0, 1'b0, 1'b1, 1'b0, 16'h0,
                  1'b1, {8'h00, model[i][7:0]}, "R5 R8 odd byte read");
            verify_word(i, "R5 word after bytes");
        end

        // R1 modifier sweep on word 5
        for (int m = 0; m < 64; m++) begin
            bit hit;
            hit = (6'(m) == AM_U) || (6'(m) == AM_S);
            cycle(6'(m), waddr(16'h0, BASE, 5, 1'b0), 1'b0, 1'b1, 1'b1, 1'b1,
                  16'(m * 16'h0203 + 1), hit, 16'h0, "R1 modifier sweep");
            if (hit) model[5] = 16'(m * 16'h0203 + 1);
            verify_word(5, "R1 R9 word 5 after modifier");
        end

        // R3 R9 foreign bases
        for (int b = 0; b < 128; b++) begin
            if (7'(b) != BASE)
                cycle(AM_U, waddr(16'h0, 7'(b), b, 1'b0), 1'b0, 1'b1, 1'b1, 1'b1, 16'hDEAD,
                      1'b0, 16'h0, "R3 R9 foreign base");
        end
        for (int i = 0; i < 128; i += 9) verify_word(i, "R9 words after foreign base");

        // R4 longword, R6 misaligned word
        cycle(AM_U, waddr(16'h0, BASE, 9, 1'b0), 1'b1, 1'b1, 1'b1, 1'b1, 16'hAAAA,
              1'b0, 16'h0, "R4 longword write");
        cycle(AM_S, waddr(16'h0, BASE, 9, 1'b0), 1'b1, 1'b0, 1'b1, 1'b1, 16'h0,
              1'b0, 16'h0, "R4 longword read");
        cycle(AM_U, waddr(16'h0, BASE, 9, 1'b1), 1'b0, 1'b1, 1'b1, 1'b1, 16'h5555,
              1'b0, 16'h0, "R6 misaligned word");
        verify_word(9, "R4 R6 word 9 unchanged");
        verify_word(255, "R3 top word");
        verify_word(0, "R3 bottom word");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule